// File: doc/BRIEF.md
# Serial Port Character Buffering and Flow Control

This block holds the characters that a serial port sends and receives. A transmit FIFO takes characters from the bus side and hands them to the transmit shifter. A receive FIFO takes characters from the receive shifter and hands them to the bus side. Both FIFOs are 32 entries of 8 bits. They are read in show-ahead fashion: the oldest entry sits on the read data output, and a read strobe removes it.

Around the two FIFOs the block produces the fill counts, the full and empty flags, and two level interrupts that compare each count against a programmable threshold. It keeps two sticky overrun flags that record characters dropped because a FIFO was full. It also drives the active-low ready-to-send output. That output follows the receive fill level when flow control is on and the receiver enable when flow control is off, and a direct override can replace it.

Top module: `serial_fifo_ctrl`

## Requirements
- R1: Each FIFO stores up to 32 characters and returns them in the order written. The oldest entry is shown on the read data output whenever the FIFO is not empty. The count outputs give the number of stored entries (0 to 32), full is 1 exactly at 32 and empty is 1 exactly at 0.
- R2: A write strobe while a FIFO is full does not store the character. A read strobe in the same cycle still removes the oldest entry.
- R3: A write strobe that is dropped because the FIFO is full sets that FIFO's overrun flag on the following clock edge.
- R4: An overrun flag stays at 1 until its clear strobe is 1 in a cycle with no new dropped write. A dropped write and a clear in the same cycle leave the flag at 1.
- R5: A read strobe on an empty FIFO has no effect. If a write arrives in the same cycle, that character is stored.
- R6: The FIFO clear input empties both FIFOs at the next edge. Reads and writes in that cycle are ignored and set no overrun flag. The overrun flags are not changed by the clear.
- R7: The transmit interrupt is 1 exactly while the transmit count is strictly below the transmit threshold.
- R8: The receive interrupt is 1 exactly while the receive count is greater than or equal to the receive threshold.
- R9: With flow control on and no override, the ready-to-send output is 0 while the receive count is below the receive threshold and 1 once the count reaches it.
- R10: With flow control off and no override, the ready-to-send output is 0 when the receiver enable is 1 and 1 when it is 0.
- R11: While the override enable is 1, the ready-to-send output equals the override value.
- R12: A read and a write in the same cycle on a FIFO that is neither empty nor full leave the count unchanged and keep the entries in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txWrEn | input | 1 | Bus-side write strobe for the transmit FIFO |
| txWrData | input | 8 | Character to write into the transmit FIFO |
| txRdEn | input | 1 | Transmitter read strobe for the transmit FIFO |
| txRdData | output | 8 | Oldest transmit character |
| rxWrEn | input | 1 | Receiver write strobe for the receive FIFO |
| rxWrData | input | 8 | Received character |
| rxRdEn | input | 1 | Bus-side read strobe for the receive FIFO |
| rxRdData | output | 8 | Oldest received character |
| fifoClr | input | 1 | Empties both FIFOs |
| txLevel | input | 6 | Transmit interrupt threshold |
| rxLevel | input | 6 | Receive interrupt and flow-control threshold |
| flowEn | input | 1 | Flow control on |
| rxEnable | input | 1 | Receiver enabled |
| txOvrClr | input | 1 | Write-1 clear of the transmit overrun flag |
| rxOvrClr | input | 1 | Write-1 clear of the receive overrun flag |
| rtsOvrEn | input | 1 | Ready-to-send override enable |
| rtsOvrVal | input | 1 | Ready-to-send override value |
| txCount | output | 6 | Transmit FIFO fill count |
| rxCount | output | 6 | Receive FIFO fill count |
| txFull | output | 1 | Transmit FIFO full |
| txEmpty | output | 1 | Transmit FIFO empty |
| rxFull | output | 1 | Receive FIFO full |
| rxEmpty | output | 1 | Receive FIFO empty |
| txIrq | output | 1 | Transmit level interrupt |
| rxIrq | output | 1 | Receive level interrupt |
| txOverrun | output | 1 | Sticky transmit overrun flag |
| rxOverrun | output | 1 | Sticky receive overrun flag |
| rtsOut | output | 1 | Ready-to-send output, active low |

## Verification
The bench fills both FIFOs past 32 entries while still writing. A design that wraps its pointer or count there would overwrite the oldest data or report a count of zero. The bench also holds a clear strobe on an overrun flag while dropped writes continue, so a design that lets the clear win would lose the flag. It reads empty FIFOs and clears them while traffic is active: a design that lets those reads through would underflow the count, and one that lets dropped writes through during a clear would raise an overrun or leave entries behind. The thresholds are swept across 0, 32 and values beyond 32, and the flow-control and override modes are toggled throughout, so a comparison off by one or a mode select that is swapped shows up at once on the interrupt or ready-to-send outputs.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  // Per-FIFO strobes issued by the control logic to a FIFO datapath.
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifoStrobe_t;

endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo
  import sfc_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.clear) begin
      mem[wrPtr] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strobe.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      unique case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdData = mem[rdPtr];
  assign full   = (count == FULL_CNT);
  assign empty  = (count == '0);

  // Checks on the datapath.
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> empty);

  p_push_pop_count_r12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && strobe.pop && !strobe.clear) |=> count == $past(count));

  p_no_push_when_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !strobe.push);

endmodule

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
  import sfc_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txWrEn,
  input  logic             txRdEn,
  input  logic             rxWrEn,
  input  logic             rxRdEn,
  input  logic             fifoClr,
  input  logic [CNT_W-1:0] txLevel,
  input  logic [CNT_W-1:0] rxLevel,
  input  logic             flowEn,
  input  logic             rxEnable,
  input  logic             txOvrClr,
  input  logic             rxOvrClr,
  input  logic             rtsOvrEn,
  input  logic             rtsOvrVal,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             txFull,
  input  logic             txEmpty,
  input  logic             rxFull,
  input  logic             rxEmpty,
  output fifoStrobe_t      txStrobe,
  output fifoStrobe_t      rxStrobe,
  output logic             txIrq,
  output logic             rxIrq,
  output logic             txOverrun,
  output logic             rxOverrun,
  output logic             rtsOut
);

  logic txDrop;
  logic rxDrop;
  logic rxAtLevel;

  // Strobe generation: clear wins, full drops writes, empty ignores reads.
  always_comb begin
    txStrobe.clear = fifoClr;
    txStrobe.push  = txWrEn && !txFull && !fifoClr;
    txStrobe.pop   = txRdEn && !txEmpty && !fifoClr;
    rxStrobe.clear = fifoClr;
    rxStrobe.push  = rxWrEn && !rxFull && !fifoClr;
    rxStrobe.pop   = rxRdEn && !rxEmpty && !fifoClr;
  end

  assign txDrop = txWrEn && txFull && !fifoClr;
  assign rxDrop = rxWrEn && rxFull && !fifoClr;

  // Sticky overrun flags; a new drop outranks a clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOverrun <= 1'b0;
      rxOverrun <= 1'b0;
    end else begin
      txOverrun <= txDrop || (txOverrun && !txOvrClr);
      rxOverrun <= rxDrop || (rxOverrun && !rxOvrClr);
    end
  end

  assign rxAtLevel = (rxCount >= rxLevel);
  assign txIrq     = (txCount < txLevel);
  assign rxIrq     = rxAtLevel;

  always_comb begin
    if (rtsOvrEn)    rtsOut = rtsOvrVal;
    else if (flowEn) rtsOut = rxAtLevel;
    else             rtsOut = !rxEnable;
  end

  // Checks on the control.
  p_tx_ovr_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txWrEn && txFull && !fifoClr) |=> txOverrun);

  p_rx_ovr_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rxWrEn && rxFull && !fifoClr) |=> rxOverrun);

  p_tx_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txOverrun && !txOvrClr) |=> txOverrun);

  p_rx_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverrun && !rxOvrClr) |=> rxOverrun);

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxRdEn && rxEmpty && !rxWrEn) |=> rxEmpty);

  p_clear_keeps_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fifoClr && !txOvrClr) |=> txOverrun == $past(txOverrun));

endmodule

// File: rtl/serial_fifo_ctrl.sv
module serial_fifo_ctrl
  import sfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              txRdEn,
  output logic [DATA_W-1:0] txRdData,
  input  logic              rxWrEn,
  input  logic [DATA_W-1:0] rxWrData,
  input  logic              rxRdEn,
  output logic [DATA_W-1:0] rxRdData,
  input  logic              fifoClr,
  input  logic [CNT_W-1:0]  txLevel,
  input  logic [CNT_W-1:0]  rxLevel,
  input  logic              flowEn,
  input  logic              rxEnable,
  input  logic              txOvrClr,
  input  logic              rxOvrClr,
  input  logic              rtsOvrEn,
  input  logic              rtsOvrVal,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic              txFull,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              txOverrun,
  output logic              rxOverrun,
  output logic              rtsOut
);

  fifoStrobe_t txStrobe;
  fifoStrobe_t rxStrobe;

  sfc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txWrEn    (txWrEn),
    .txRdEn    (txRdEn),
    .rxWrEn    (rxWrEn),
    .rxRdEn    (rxRdEn),
    .fifoClr   (fifoClr),
    .txLevel   (txLevel),
    .rxLevel   (rxLevel),
    .flowEn    (flowEn),
    .rxEnable  (rxEnable),
    .txOvrClr  (txOvrClr),
    .rxOvrClr  (rxOvrClr),
    .rtsOvrEn  (rtsOvrEn),
    .rtsOvrVal (rtsOvrVal),
    .txCount   (txCount),
    .rxCount   (rxCount),
    .txFull    (txFull),
    .txEmpty   (txEmpty),
    .rxFull    (rxFull),
    .rxEmpty   (rxEmpty),
    .txStrobe  (txStrobe),
    .rxStrobe  (rxStrobe),
    .txIrq     (txIrq),
    .rxIrq     (rxIrq),
    .txOverrun (txOverrun),
    .rxOverrun (rxOverrun),
    .rtsOut    (rtsOut)
  );

  sfc_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txFifo (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (txStrobe),
    .wrData (txWrData),
    .rdData (txRdData),
    .count  (txCount),
    .full   (txFull),
    .empty  (txEmpty)
  );

  sfc_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxFifo (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (rxStrobe),
    .wrData (rxWrData),
    .rdData (rxRdData),
    .count  (rxCount),
    .full   (rxFull),
    .empty  (rxEmpty)
  );

endmodule

// File: tb/serial_fifo_ctrl_tb.sv
module serial_fifo_ctrl_tb;

  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txWrEn = 0, txRdEn = 0, rxWrEn = 0, rxRdEn = 0, fifoClr = 0;
  logic [7:0] txWrData = 0, rxWrData = 0;
  logic [5:0] txLevel = 0, rxLevel = 0;
  logic       flowEn = 0, rxEnable = 0, txOvrClr = 0, rxOvrClr = 0;
  logic       rtsOvrEn = 0, rtsOvrVal = 0;
  logic [7:0] txRdData, rxRdData;
  logic [5:0] txCount, rxCount;
  logic       txFull, txEmpty, rxFull, rxEmpty, txIrq, rxIrq;
  logic       txOverrun, rxOverrun, rtsOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // Reference model state.
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  bit         mTxOvr = 0, mRxOvr = 0;

  always #2.5 clk = ~clk;

  serial_fifo_ctrl u_dut (
    .clk(clk), .rstN(rstN),
    .txWrEn(txWrEn), .txWrData(txWrData), .txRdEn(txRdEn), .txRdData(txRdData),
    .rxWrEn(rxWrEn), .rxWrData(rxWrData), .rxRdEn(rxRdEn), .rxRdData(rxRdData),
    .fifoClr(fifoClr), .txLevel(txLevel), .rxLevel(rxLevel),
    .flowEn(flowEn), .rxEnable(rxEnable), .txOvrClr(txOvrClr), .rxOvrClr(rxOvrClr),
    .rtsOvrEn(rtsOvrEn), .rtsOvrVal(rtsOvrVal),
    .txCount(txCount), .rxCount(rxCount), .txFull(txFull), .txEmpty(txEmpty),
    .rxFull(rxFull), .rxEmpty(rxEmpty), .txIrq(txIrq), .rxIrq(rxIrq),
    .txOverrun(txOverrun), .rxOverrun(rxOverrun), .rtsOut(rtsOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic compareAll();
    int expRts;
    chk("R1", "txCount", int'(txCount), txQ.size());
    chk("R1", "rxCount", int'(rxCount), rxQ.size());
    chk("R1", "txFull", int'(txFull), int'(txQ.size() == DEPTH));
    chk("R1", "txEmpty", int'(txEmpty), int'(txQ.size() == 0));
    chk("R1", "rxFull", int'(rxFull), int'(rxQ.size() == DEPTH));
    chk("R1", "rxEmpty", int'(rxEmpty), int'(rxQ.size() == 0));
    if (txQ.size() > 0) chk("R1", "txRdData", int'(txRdData), int'(txQ[0]));
    if (rxQ.size() > 0) chk("R1", "rxRdData", int'(rxRdData), int'(rxQ[0]));
    chk("R7", "txIrq", int'(txIrq), int'(txQ.size() < int'(txLevel)));
    chk("R8", "rxIrq", int'(rxIrq), int'(rxQ.size() >= int'(rxLevel)));
    chk("R3", "txOverrun", int'(txOverrun), int'(mTxOvr));
    chk("R3", "rxOverrun", int'(rxOverrun), int'(mRxOvr));
    if (rtsOvrEn) begin
      chk("R11", "rtsOut", int'(rtsOut), int'(rtsOvrVal));
    end else if (flowEn) begin
      expRts = int'(rxQ.size() >= int'(rxLevel));
      chk("R9", "rtsOut", int'(rtsOut), expRts);
    end else begin
      chk("R10", "rtsOut", int'(rtsOut), int'(!rxEnable));
    end
  endtask

  // Behavioural update of the model at a clock edge.
  task automatic modelEdge();
    bit txDrop, rxDrop;
    txDrop = 0;
    rxDrop = 0;
    if (fifoClr) begin
      txQ.delete();
      rxQ.delete();
    end else begin
      txDrop = txWrEn && (txQ.size() == DEPTH);
      rxDrop = rxWrEn && (rxQ.size() == DEPTH);
      if (txRdEn && txQ.size() > 0) void'(txQ.pop_front());
      if (txWrEn && !txDrop) txQ.push_back(txWrData);
      if (rxRdEn && rxQ.size() > 0) void'(rxQ.pop_front());
      if (rxWrEn && !rxDrop) rxQ.push_back(rxWrData);
    end
    mTxOvr = txDrop || (mTxOvr && !txOvrClr);
    mRxOvr = rxDrop || (mRxOvr && !rxOvrClr);
  endtask

  // One cycle: inputs already set after a falling edge.
  task automatic step();
    #1;
    compareAll();
    @(posedge clk);
    modelEdge();
    cycles++;
    @(negedge clk);
  endtask

  task automatic idleInputs();
    txWrEn = 0; txRdEn = 0; rxWrEn = 0; rxRdEn = 0; fifoClr = 0;
    txOvrClr = 0; rxOvrClr = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    finishRun();
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state (R1).
    chk("R1", "reset txCount", int'(txCount), 0);
    chk("R1", "reset rxEmpty", int'(rxEmpty), 1);
    chk("R3", "reset txOverrun", int'(txOverrun), 0);
    rstN = 1;
    @(negedge clk);

    // R1/R2/R3: fill both FIFOs past full without reading.
    txLevel = 6'd32; rxLevel = 6'd32; flowEn = 1; rxEnable = 1;
    for (int i = 0; i < 40; i++) begin
      txWrEn = 1; txWrData = 8'(i * 7 + 1);
      rxWrEn = 1; rxWrData = 8'(i * 3 + 5);
      step();
    end
    // R2: write while full with a read: read happens, write dropped.
    txRdEn = 1; rxRdEn = 1;
    step();
    // R4: dropped write together with clear keeps the flag.
    txRdEn = 0; rxRdEn = 0;
    step();
    txOvrClr = 1; rxOvrClr = 1;
    step();
    chk("R4", "txOverrun set+clear", int'(txOverrun), 1);
    // R4: clear alone drops the flag.
    idleInputs(); txOvrClr = 1; rxOvrClr = 1;
    step();
    idleInputs();
    step();
    chk("R4", "txOverrun after clear", int'(txOverrun), 0);

    // R12: simultaneous read and write on a partly filled FIFO.
    for (int i = 0; i < 5; i++) begin txRdEn = 1; rxRdEn = 1; step(); end
    for (int i = 0; i < 20; i++) begin
      txWrEn = 1; txRdEn = 1; txWrData = 8'(100 + i);
      rxWrEn = 1; rxRdEn = 1; rxWrData = 8'(200 + i);
      step();
      chk("R12", "txCount steady", int'(txCount), 27);
    end
    idleInputs();

    // R6: clear during traffic with full FIFOs and pending writes.
    for (int i = 0; i < 6; i++) begin txWrEn = 1; rxWrEn = 1; step(); end
    fifoClr = 1; txWrEn = 1; rxWrEn = 1; txRdEn = 1;
    step();
    idleInputs();
    step();
    chk("R6", "txCount after clear", int'(txCount), 0);
    chk("R6", "txOverrun after clear", int'(txOverrun), 1);

    // R5: reads on empty, with and without a simultaneous write.
    txOvrClr = 1; rxOvrClr = 1;
    step();
    idleInputs();
    txRdEn = 1; rxRdEn = 1;
    step(); step();
    rxWrEn = 1; rxWrData = 8'h5a;
    step();
    idleInputs();
    step();
    chk("R5", "rxCount read-empty+write", int'(rxCount), 1);

    // R9/R10/R11 threshold and mode sweeps with random traffic.
    for (int i = 0; i < 6000; i++) begin
      if (i % 200 == 0) begin
        txLevel = 6'($urandom_range(0, 40));
        rxLevel = 6'($urandom_range(0, 40));
        flowEn = 1'($urandom_range(0, 1));
      end
      rxEnable  = ($urandom_range(0, 15) != 0);
      rtsOvrEn  = ($urandom_range(0, 9) == 0);
      rtsOvrVal = 1'($urandom_range(0, 1));
      txWrEn    = ($urandom_range(0, 99) < ((i / 1000) % 2 ? 70 : 35));
      txRdEn    = ($urandom_range(0, 99) < ((i / 1000) % 2 ? 30 : 65));
      rxWrEn    = ($urandom_range(0, 99) < ((i / 1500) % 2 ? 75 : 40));
      rxRdEn    = ($urandom_range(0, 99) < ((i / 1500) % 2 ? 25 : 60));
      txWrData  = 8'($urandom);
      rxWrData  = 8'($urandom);
      fifoClr   = ($urandom_range(0, 499) == 0);
      txOvrClr  = ($urandom_range(0, 49) == 0);
      rxOvrClr  = ($urandom_range(0, 49) == 0);
      step();
    end
    idleInputs();
    rtsOvrEn = 0;
    step();
    finishRun();
  end

endmodule